// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block gives a host indirect access to a small file of PHY delay settings. The host does not address the settings directly. It uses one 32-bit access word. The host writes a target index and a byte of write data into that word, then sets one of two request bits. The port carries out the transfer and reports completion through an acknowledge bit. The acknowledge stays up until the host withdraws the request. After that the acknowledge drops and the port can take a new transfer.

The delay file holds 64 entries of 8 bits. Its entries set the per-speed-mode input delays and the DLL delays for the clock, high-speed and strobe paths. The index map places the per-mode input delays at 0x00 to 0x08, the output clock DLL at 0x0b, the high-speed DLL at 0x0c and the strobe DLL at 0x0d. The host applies a bounded timeout of about 10 µs to each acknowledge edge, so the completion latency is a parameter and stays short. The index and write data are latched when a request is accepted. Host writes made while the transfer is running therefore cannot corrupt it.

Top module: `phy_dly_access_port`

## Requirements
- R1: In the access word, bits 5:0 hold the index, bits 15:8 the write byte, bit 24 the write request and bit 25 the read request, and all of these read back as written. Bits 23:16 return the read byte and bit 26 returns the acknowledge. Host writes to bits 23:16 and 26 have no effect. Bits 31:27 and 7:6 read as zero.
- R2: After reset the access word reads all zeros and every delay entry reads zero.
- R3: The acknowledge rises exactly ACK_LATENCY clock cycles after the edge that makes a single request bit visible in the access word.
- R4: A write transfer stores the write byte into the delay entry at the index, where a later read returns it.
- R5: A read transfer places the addressed entry in bits 23:16 by the time the acknowledge is high. The field then keeps that value after the acknowledge falls and through later write transfers, until the next read completes.
- R6: The acknowledge stays high while either request bit is set. It falls one cycle after both request bits are seen clear.
- R7: If the write and read requests are set together, the port ignores them: the acknowledge stays low and no entry changes.
- R8: Index and write-byte changes made after a request is accepted do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr_en | input | 1 | Strobe that loads acc_wdata into the access word |
| acc_wdata | input | 32 | Value written by the host to the access word |
| acc_rdata | output | 32 | Current content of the access word |

## Verification
The bound checker watches the handshake on every cycle. It checks that the acknowledge is held while a request is present and is released one cycle after both requests clear. It checks that a double request never raises the acknowledge, and that the read byte changes only on an acknowledge rising edge. The bench scenarios are the only evidence for the exact rise latency, for which entry a transfer touched, and for the immunity of a running transfer to host rewrites. They also cover the zero state after reset and the read-only fields of the access word.

// File: rtl/phy_acc_pkg.sv
`timescale 1ns/1ps
package phy_acc_pkg;
   // Fixed slot positions inside the 32-bit access word
   localparam int unsigned SLOT_W   = 8;
   localparam int unsigned WDAT_LSB = 8;
   localparam int unsigned RDAT_LSB = 16;
   localparam int unsigned WREQ_BIT = 24;
   localparam int unsigned RREQ_BIT = 25;
   localparam int unsigned ACK_BIT  = 26;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } acc_state_e;
endpackage

// File: rtl/phy_acc_hostreg.sv
`timescale 1ns/1ps
module phy_acc_hostreg
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdat_o,
   output logic              wreq_o,
   output logic              rreq_o
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[31:26], wdata[23:16], wdata[7:ADDR_W],
                           wdata[15:WDAT_LSB+DATA_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         wdat_o <= '0;
         wreq_o <= 1'b0;
         rreq_o <= 1'b0;
      end else if (wr_en) begin
         addr_o <= wdata[ADDR_W-1:0];
         wdat_o <= wdata[WDAT_LSB +: DATA_W];
         wreq_o <= wdata[WREQ_BIT];
         rreq_o <= wdata[RREQ_BIT];
      end
   end
endmodule

// File: rtl/phy_acc_regfile.sv
`timescale 1ns/1ps
module phy_acc_regfile #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdat,
   output logic [DATA_W-1:0] rdat
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdat;
      end
   end

   assign rdat = mem[addr];
endmodule

// File: rtl/phy_acc_seq.sv
`timescale 1ns/1ps
module phy_acc_seq
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ACK_LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wreq,
   input  logic              rreq,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdat_in,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdat,
   input  logic [DATA_W-1:0] rf_rdat,
   output logic [DATA_W-1:0] rdat_o,
   output logic              ack_o,
   output logic              idle_o
);
   localparam int unsigned CNT_W = $clog2(ACK_LATENCY + 1);

   acc_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q;
   logic              is_wr_q;
   logic              accept, fire, is_wr;

   assign idle_o  = (state_q == ST_IDLE);
   assign accept  = idle_o && (wreq ^ rreq);
   // While idle the live fields are used; afterwards the captured copy
   assign rf_addr = idle_o ? addr_in : addr_q;
   assign rf_wdat = idle_o ? wdat_in : wdat_q;
   assign is_wr   = idle_o ? wreq    : is_wr_q;
   assign rf_we   = fire && is_wr;
   assign ack_o   = (state_q == ST_DONE);

   generate
      if (ACK_LATENCY == 1) begin : g_lat_one
         assign fire = accept;
      end else begin : g_lat_cnt
         logic [CNT_W-1:0] cnt_q;
         assign fire = (state_q == ST_BUSY) && (cnt_q == CNT_W'(1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (accept)              cnt_q <= CNT_W'(ACK_LATENCY - 1);
            else if (state_q == ST_BUSY)  cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdat_q  <= '0;
         is_wr_q <= 1'b0;
         rdat_o  <= '0;
      end else begin
         if (accept) begin
            addr_q  <= addr_in;
            wdat_q  <= wdat_in;
            is_wr_q <= wreq;
         end
         if (fire && !is_wr) rdat_o <= rf_rdat;
         case (state_q)
            ST_IDLE: if (accept) state_q <= fire ? ST_DONE : ST_BUSY;
            ST_BUSY: if (fire)   state_q <= ST_DONE;
            ST_DONE: if (!wreq && !rreq) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/phy_dly_access_port.sv
`timescale 1ns/1ps
module phy_dly_access_port
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ACK_LATENCY = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_wr_en,
   input  logic [31:0] acc_wdata,
   output logic [31:0] acc_rdata
);
   generate
      if (ACK_LATENCY < 1) begin : g_bad_lat
         $error("ACK_LATENCY must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
         $error("ADDR_W must be in 1..6");
      end
      if (DATA_W < 1 || DATA_W > SLOT_W) begin : g_bad_data
         $error("DATA_W must fit an 8-bit slot");
      end
   endgenerate

   logic [ADDR_W-1:0] host_addr, rf_addr;
   logic [DATA_W-1:0] host_wdat, rf_wdat, rf_q, rdat;
   logic              host_wr, host_rd, rf_we, ack, seq_idle;

   phy_acc_hostreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) hostreg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(acc_wr_en), .wdata(acc_wdata),
      .addr_o(host_addr), .wdat_o(host_wdat), .wreq_o(host_wr), .rreq_o(host_rd)
   );

   phy_acc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_LATENCY(ACK_LATENCY)) seq_i (
      .clk(clk), .rst_n(rst_n), .wreq(host_wr), .rreq(host_rd),
      .addr_in(host_addr), .wdat_in(host_wdat),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdat(rf_wdat), .rf_rdat(rf_q),
      .rdat_o(rdat), .ack_o(ack), .idle_o(seq_idle)
   );

   phy_acc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regfile_i (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .addr(rf_addr),
      .wdat(rf_wdat), .rdat(rf_q)
   );

   always_comb begin
      acc_rdata = '0;
      acc_rdata[ADDR_W-1:0]          = host_addr;
      acc_rdata[WDAT_LSB +: DATA_W]  = host_wdat;
      acc_rdata[RDAT_LSB +: DATA_W]  = rdat;
      acc_rdata[WREQ_BIT]            = host_wr;
      acc_rdata[RREQ_BIT]            = host_rd;
      acc_rdata[ACK_BIT]             = ack;
   end
endmodule

// File: rtl/phy_dly_access_chk.sv
`timescale 1ns/1ps
module phy_dly_access_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic              rd,
   input logic              ack,
   input logic              idle,
   input logic [DATA_W-1:0] rdat
);
   assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !wr && !rd) |=> !ack);

   assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (wr || rd)) |=> ack);

   assert_both_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && wr && rd) |=> !ack);

   assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdat) |-> $rose(ack));
endmodule

bind phy_dly_access_port phy_dly_access_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd),
   .ack(ack), .idle(seq_idle), .rdat(rdat)
);

// File: tb/phy_dly_access_port_tb_top.sv
`timescale 1ns/1ps
module phy_dly_access_port_tb_top;
   localparam int LAT   = 4;
   localparam int NVEC  = 8;
   // {index[13:8], byte[7:0]}
   localparam logic [13:0] VEC [NVEC] = '{
      {6'h00, 8'h5a}, {6'h08, 8'hc3}, {6'h0b, 8'h01}, {6'h0c, 8'hfe},
      {6'h0d, 8'h77}, {6'h3f, 8'h80}, {6'h05, 8'h3c}, {6'h20, 8'hff}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_wr_en = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;

   phy_dly_access_port #(.ACK_LATENCY(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_wr_en(acc_wr_en),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
   );

   function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] d,
                                      input logic w, input logic r);
      return {6'b0, r, w, 8'h00, d, 2'b00, a};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] w);
      @(negedge clk);
      acc_wr_en = 1'b1;
      acc_wdata = w;
      @(negedge clk);
      acc_wr_en = 1'b0;
   endtask

   // full four-phase transfer; returns read byte field seen while ack high
   task automatic xfer(input logic [5:0] a, input logic [7:0] d, input logic is_wr,
                       output logic [7:0] got);
      int n = 0;
      put(mk(a, d, is_wr, !is_wr));
      while (!acc_rdata[26] && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk("R3 ack latency", 32'(n), 32'(LAT));
      got = acc_rdata[23:16];
      put(mk(a, d, 1'b0, 1'b0));
      chk("R6 ack held until release seen", {31'b0, acc_rdata[26]}, 32'd1);
      @(negedge clk);
      chk("R6 ack falls after release", {31'b0, acc_rdata[26]}, 32'd0);
   endtask

   initial begin
      logic [7:0] got;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 access word after reset", acc_rdata, 32'h0);
      // R1: read-only slots ignore host writes, reserved bits read zero
      put(32'hFCFF_FFFF);
      chk("R1 field readback", acc_rdata, 32'h0000_FF3F);
      put(32'h0);
      xfer(6'h2a, 8'h00, 1'b0, got);
      chk("R2 delay entry after reset", {24'b0, got}, 32'h0);

      // vector table: write then read back each entry
      for (int i = 0; i < NVEC; i++) begin
         xfer(VEC[i][13:8], VEC[i][7:0], 1'b1, got);
      end
      for (int i = 0; i < NVEC; i++) begin
         xfer(VEC[i][13:8], 8'h00, 1'b0, got);
         chk("R4 stored byte read back", {24'b0, got}, {24'b0, VEC[i][7:0]});
      end

      // R5: read byte holds after ack falls and across a write transfer
      xfer(6'h0c, 8'h00, 1'b0, held);
      chk("R5 read byte after ack fall", {24'b0, acc_rdata[23:16]}, 32'h0000_00fe);
      xfer(6'h01, 8'h42, 1'b1, got);
      chk("R5 read byte kept over write", {24'b0, acc_rdata[23:16]}, {24'b0, held});

      // R7: both request bits together are ignored
      put(mk(6'h0d, 8'h99, 1'b1, 1'b1));
      for (int i = 0; i < LAT + 3; i++) @(negedge clk);
      chk("R7 no ack on double request", {31'b0, acc_rdata[26]}, 32'd0);
      put(32'h0);
      xfer(6'h0d, 8'h00, 1'b0, got);
      chk("R7 entry untouched", {24'b0, got}, 32'h0000_0077);

      // R8: rewrite index and byte while the write is in flight
      put(mk(6'h10, 8'h11, 1'b1, 1'b0));
      put(mk(6'h11, 8'h22, 1'b1, 1'b0));
      for (int i = 0; i < LAT + 2; i++) @(negedge clk);
      chk("R8 ack for first request", {31'b0, acc_rdata[26]}, 32'd1);
      put(32'h0);
      @(negedge clk);
      xfer(6'h10, 8'h00, 1'b0, got);
      chk("R8 captured index written", {24'b0, got}, 32'h0000_0011);
      xfer(6'h11, 8'h00, 1'b0, got);
      chk("R8 later index untouched", {24'b0, got}, 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule